// File: doc/BRIEF.md
# Threshold-Triggered Transmit/Receive FIFO Pair

This block sits between a bus-side register interface and a serial shift engine. It holds two queues. The transmit queue is filled by bus writes and drained by the shifter. The receive queue is filled by the shifter and drained by bus reads. Each side raises one request line, which serves as both the interrupt request and the DMA request. On the transmit side the request asks for more data. On the receive side it asks for the queue to be emptied.

When each request fires is programmable through a two-bit policy code:

| Code | Transmit request is high when | Receive request is high when |
|------|-------------------------------|------------------------------|
| 0, 3 | there is any free space | any data is held |
| 1 | at least half the space is free | the queue is at least half full |
| 2 | the queue is completely empty | the queue is completely full |

When the global enable is low, each side shrinks to a single-entry holding register. A width-mode input selects how much of each bus access is used: the full 32-bit word, or only the low byte.

Both request lines are registered. Their next value is computed from the occupancy the queue will have after the current clock edge. As a result, each request changes on the same edge as the level it depends on.

Top module: `fifo_pair_trig`

## Requirements
- R1: While `rstN` is low, `txLevel`, `rxLevel`, `txReq`, `rxReq`, `txOvf`, `txUnf`, `rxOvf` and `rxUnf` are all 0.
- R2: Each queue holds up to 8 entries when `fifoEn` is 1. It returns entries in the order they were written. An accepted write raises the level by one and an accepted read lowers it by one.
- R3: When `txThr` is 0 or 3, `txReq` is 1 exactly when `txLevel` is below the capacity.
- R4: When `txThr` is 1, `txReq` is 1 exactly when the free space (capacity minus `txLevel`) is at least the half mark. The half mark is 4 when `fifoEn` is 1, and 1 when `fifoEn` is 0.
- R5: When `txThr` is 2, `txReq` is 1 exactly when `txLevel` is 0.
- R6: When `rxThr` is 0 or 3, `rxReq` is 1 exactly when `rxLevel` is at least 1.
- R7: When `rxThr` is 1, `rxReq` is 1 exactly when `rxLevel` is at least the half mark.
- R8: When `rxThr` is 2, `rxReq` is 1 exactly when `rxLevel` equals the capacity.
- R9: After every clock edge, each request reflects the level produced by that same edge and the policy code sampled at that edge. There is no extra cycle of lag.
- R10: A write into a full queue is dropped. The level and the stored contents stay unchanged, and a sticky overflow flag is set (`txOvf` for a bus write, `rxOvf` for a shifter push). Only reset clears it.
- R11: A read from an empty queue is dropped. The level stays 0, and a sticky underflow flag is set (`txUnf` for a shifter pop, `rxUnf` for a bus read). Only reset clears it.
- R12: When `fifoEn` is 0, the capacity is 1 and the half mark is 1. At the first edge after `fifoEn` changes, both queues are emptied. Any push or pop presented in that cycle is ignored.
- R13: When `wide32` is 0, a bus write stores only bits [7:0], zero-extended. In the same mode, `busRdData` shows only bits [7:0] of the head entry, with bits [31:8] forced to 0. When `wide32` is 1, full 32-bit words pass through. The shifter side always moves full words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | 1 = 8-entry queues, 0 = single-entry holding registers |
| txThr | input | 2 | Transmit request policy code |
| rxThr | input | 2 | Receive request policy code |
| wide32 | input | 1 | 1 = 32-bit bus access, 0 = byte access |
| busWrValid | input | 1 | Bus push into the transmit queue |
| busWrData | input | 32 | Bus write data |
| busRdReq | input | 1 | Bus pop from the receive queue |
| busRdData | output | 32 | Head of the receive queue, width-masked |
| shTxPop | input | 1 | Shifter pop from the transmit queue |
| shTxData | output | 32 | Head of the transmit queue |
| shRxPush | input | 1 | Shifter push into the receive queue |
| shRxData | input | 32 | Shifter receive word |
| txReq | output | 1 | Transmit data-empty request (interrupt and DMA) |
| rxReq | output | 1 | Receive-complete request (interrupt and DMA) |
| txLevel | output | 4 | Transmit queue occupancy |
| rxLevel | output | 4 | Receive queue occupancy |
| txOvf | output | 1 | Sticky transmit overflow |
| txUnf | output | 1 | Sticky transmit underflow |
| rxOvf | output | 1 | Sticky receive overflow |
| rxUnf | output | 1 | Sticky receive underflow |

## Verification
A corrupted level counter shows up at the ports at the next clock edge in two ways:
- The request line disagrees with the policy for the reported level.
- The level walks past a boundary that should have held it.

A wrong pointer stays hidden until the affected entry reaches the head. There it appears as a head word out of order, which can be several pushes later. The bench therefore drains each queue fully and compares every head word. A missed flush after an enable change appears at the next edge as a nonzero level. It also appears as a request that does not match single-entry capacity.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  localparam int unsigned FIFO_DEPTH = 8;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned PTR_W      = $clog2(FIFO_DEPTH);
  localparam int unsigned LVL_W      = PTR_W + 1;

  typedef enum logic [1:0] {
    THR_LOOSE = 2'd0,
    THR_HALF  = 2'd1,
    THR_EDGE  = 2'd2,
    THR_RSVD  = 2'd3
  } thr_e;

  typedef struct packed {
    logic             txWe;
    logic [PTR_W-1:0] txWrIdx;
    logic [PTR_W-1:0] txRdIdx;
    logic             rxWe;
    logic [PTR_W-1:0] rxWrIdx;
    logic [PTR_W-1:0] rxRdIdx;
  } strobe_t;
endpackage

// File: rtl/fpt_track.sv
module fpt_track
  import fpt_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [LVL_W-1:0] capLvl,
  input  logic [LVL_W-1:0] halfLvl,
  input  logic [1:0]       thrSel,
  input  logic             pushReq,
  input  logic             popReq,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic             wrEn,
  output logic [LVL_W-1:0] level,
  output logic             reqOut,
  output logic             ovfFlag,
  output logic             unfFlag
);
  logic             isFull, isEmpty, pushOk, popOk, reqNext;
  logic [LVL_W-1:0] nextLevel;

  assign isFull  = (level >= capLvl);
  assign isEmpty = (level == '0);
  assign pushOk  = pushReq && !isFull && !flush;
  assign popOk   = popReq && !isEmpty && !flush;
  assign wrEn    = pushOk;
  assign nextLevel = flush ? '0 : (level + LVL_W'(pushOk) - LVL_W'(popOk));

  generate
    if (IS_TX) begin : g_txPolicy
      logic [LVL_W-1:0] freeNext;
      assign freeNext = capLvl - nextLevel;
      always_comb begin
        case (thr_e'(thrSel))
          THR_HALF: reqNext = (freeNext >= halfLvl);
          THR_EDGE: reqNext = (nextLevel == '0);
          default:  reqNext = (nextLevel < capLvl);
        endcase
      end
    end else begin : g_rxPolicy
      always_comb begin
        case (thr_e'(thrSel))
          THR_HALF: reqNext = (nextLevel >= halfLvl);
          THR_EDGE: reqNext = (nextLevel >= capLvl);
          default:  reqNext = (nextLevel != '0);
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx   <= '0;
      rdIdx   <= '0;
      level   <= '0;
      reqOut  <= 1'b0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else begin
      level  <= nextLevel;
      reqOut <= reqNext;
      if (flush) begin
        wrIdx <= '0;
        rdIdx <= '0;
      end else begin
        if (pushOk) wrIdx <= wrIdx + 1'b1;
        if (popOk)  rdIdx <= rdIdx + 1'b1;
        if (pushReq && isFull)  ovfFlag <= 1'b1;
        if (popReq && isEmpty)  unfFlag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpt_ctrl.sv
module fpt_ctrl
  import fpt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [1:0]       txThr,
  input  logic [1:0]       rxThr,
  input  logic             busWrValid,
  input  logic             busRdReq,
  input  logic             shTxPop,
  input  logic             shRxPush,
  output strobe_t          strobes,
  output logic             txReq,
  output logic             rxReq,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic             txOvf,
  output logic             txUnf,
  output logic             rxOvf,
  output logic             rxUnf
);
  localparam logic [LVL_W-1:0] FULL_CAP = LVL_W'(FIFO_DEPTH);
  localparam logic [LVL_W-1:0] FULL_HALF = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [LVL_W-1:0] ONE_LVL = LVL_W'(1);

  logic             prevEn, flush;
  logic [LVL_W-1:0] capLvl, halfLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevEn <= 1'b0;
    else       prevEn <= fifoEn;
  end

  assign flush   = (fifoEn != prevEn);
  assign capLvl  = fifoEn ? FULL_CAP : ONE_LVL;
  assign halfLvl = fifoEn ? FULL_HALF : ONE_LVL;

  fpt_track #(.IS_TX(1'b1)) u_txTrack (
    .clk(clk), .rstN(rstN), .flush(flush), .capLvl(capLvl), .halfLvl(halfLvl),
    .thrSel(txThr), .pushReq(busWrValid), .popReq(shTxPop),
    .wrIdx(strobes.txWrIdx), .rdIdx(strobes.txRdIdx), .wrEn(strobes.txWe),
    .level(txLevel), .reqOut(txReq), .ovfFlag(txOvf), .unfFlag(txUnf)
  );

  fpt_track #(.IS_TX(1'b0)) u_rxTrack (
    .clk(clk), .rstN(rstN), .flush(flush), .capLvl(capLvl), .halfLvl(halfLvl),
    .thrSel(rxThr), .pushReq(shRxPush), .popReq(busRdReq),
    .wrIdx(strobes.rxWrIdx), .rdIdx(strobes.rxRdIdx), .wrEn(strobes.rxWe),
    .level(rxLevel), .reqOut(rxReq), .ovfFlag(rxOvf), .unfFlag(rxUnf)
  );
endmodule

// File: rtl/fpt_data.sv
module fpt_data
  import fpt_pkg::*;
(
  input  logic              clk,
  input  strobe_t           strobes,
  input  logic              wide32,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] shRxData,
  output logic [DATA_W-1:0] shTxData,
  output logic [DATA_W-1:0] busRdData
);
  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0] txMem [FIFO_DEPTH];
  logic [DATA_W-1:0] rxMem [FIFO_DEPTH];
  logic [DATA_W-1:0] txIn, rxHead;

  assign txIn = wide32 ? busWrData : (busWrData & BYTE_MASK);

  always_ff @(posedge clk) begin
    if (strobes.txWe) txMem[strobes.txWrIdx] <= txIn;
    if (strobes.rxWe) rxMem[strobes.rxWrIdx] <= shRxData;
  end

  assign shTxData  = txMem[strobes.txRdIdx];
  assign rxHead    = rxMem[strobes.rxRdIdx];
  assign busRdData = wide32 ? rxHead : (rxHead & BYTE_MASK);
endmodule

// File: rtl/fifo_pair_trig.sv
module fifo_pair_trig
  import fpt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic [1:0]        txThr,
  input  logic [1:0]        rxThr,
  input  logic              wide32,
  input  logic              busWrValid,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdReq,
  output logic [DATA_W-1:0] busRdData,
  input  logic              shTxPop,
  output logic [DATA_W-1:0] shTxData,
  input  logic              shRxPush,
  input  logic [DATA_W-1:0] shRxData,
  output logic              txReq,
  output logic              rxReq,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              txOvf,
  output logic              txUnf,
  output logic              rxOvf,
  output logic              rxUnf
);
  strobe_t strobes;

  fpt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .txThr(txThr), .rxThr(rxThr),
    .busWrValid(busWrValid), .busRdReq(busRdReq), .shTxPop(shTxPop), .shRxPush(shRxPush),
    .strobes(strobes), .txReq(txReq), .rxReq(rxReq), .txLevel(txLevel), .rxLevel(rxLevel),
    .txOvf(txOvf), .txUnf(txUnf), .rxOvf(rxOvf), .rxUnf(rxUnf)
  );

  fpt_data u_data (
    .clk(clk), .strobes(strobes), .wide32(wide32), .busWrData(busWrData),
    .shRxData(shRxData), .shTxData(shTxData), .busRdData(busRdData)
  );
endmodule

// File: rtl/fpt_checker.sv
module fpt_checker
  import fpt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              fifoEn,
  input logic [1:0]        txThr,
  input logic [1:0]        rxThr,
  input logic              wide32,
  input logic              busWrValid,
  input logic              busRdReq,
  input logic              shTxPop,
  input logic              shRxPush,
  input logic [DATA_W-1:0] busRdData,
  input logic              txReq,
  input logic              rxReq,
  input logic [LVL_W-1:0]  txLevel,
  input logic [LVL_W-1:0]  rxLevel,
  input logic              txOvf,
  input logic              txUnf,
  input logic              rxOvf,
  input logic              rxUnf
);
  localparam logic [LVL_W-1:0] CAP_ON  = LVL_W'(FIFO_DEPTH);
  localparam logic [LVL_W-1:0] HALF_ON = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [LVL_W-1:0] ONE_LVL = LVL_W'(1);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  logic [LVL_W-1:0] capNow, halfNow;
  assign capNow  = fifoEn ? CAP_ON : ONE_LVL;
  assign halfNow = fifoEn ? HALF_ON : ONE_LVL;

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= CAP_ON) && (rxLevel <= CAP_ON));

  assert_tx_any_R3: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(txThr) == 2'd0 || $past(txThr) == 2'd3) |-> (txReq == (txLevel < $past(capNow))));

  assert_tx_half_R4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(txThr) == 2'd1) |-> (txReq == (($past(capNow) - txLevel) >= $past(halfNow))));

  assert_tx_empty_R5: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(txThr) == 2'd2) |-> (txReq == (txLevel == '0)));

  assert_rx_any_R6: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(rxThr) == 2'd0 || $past(rxThr) == 2'd3) |-> (rxReq == (rxLevel != '0)));

  assert_rx_half_R7: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(rxThr) == 2'd1) |-> (rxReq == (rxLevel >= $past(halfNow))));

  assert_rx_full_R8: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(rxThr) == 2'd2) |-> (rxReq == (rxLevel == $past(capNow))));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (busWrValid && !shTxPop && (txLevel == capNow) && $stable(fifoEn))
      |=> (txOvf && $stable(txLevel)));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txOvf || rxOvf) |=> ($past(txOvf) -> txOvf) && ($past(rxOvf) -> rxOvf));

  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (busRdReq && !shRxPush && (rxLevel == '0) && $stable(fifoEn)) |=> (rxUnf && rxLevel == '0));

  assert_tx_underflow_R11: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (shTxPop && (txLevel == '0) && $stable(fifoEn)) |=> txUnf);

  assert_bypass_cap_R12: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (!fifoEn && !$past(fifoEn)) |-> (txLevel <= ONE_LVL && rxLevel <= ONE_LVL));

  assert_byte_read_R13: assert property (@(posedge clk) disable iff (!rstN)
    !wide32 |-> (busRdData[DATA_W-1:BYTE_W] == '0));
endmodule

bind fifo_pair_trig fpt_checker u_fptChk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .txThr(txThr), .rxThr(rxThr), .wide32(wide32),
  .busWrValid(busWrValid), .busRdReq(busRdReq), .shTxPop(shTxPop), .shRxPush(shRxPush),
  .busRdData(busRdData), .txReq(txReq), .rxReq(rxReq), .txLevel(txLevel), .rxLevel(rxLevel),
  .txOvf(txOvf), .txUnf(txUnf), .rxOvf(rxOvf), .rxUnf(rxUnf)
);

// File: tb/sim_fifo_pair_trig.sv
module sim_fifo_pair_trig;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoEn = 1'b1;
  logic [1:0]  txThr = 2'd0, rxThr = 2'd0;
  logic        wide32 = 1'b1;
  logic        busWrValid = 1'b0, busRdReq = 1'b0, shTxPop = 1'b0, shRxPush = 1'b0;
  logic [31:0] busWrData = '0, shRxData = '0;
  logic [31:0] busRdData, shTxData;
  logic        txReq, rxReq, txOvf, txUnf, rxOvf, rxUnf;
  logic [3:0]  txLevel, rxLevel;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fifo_pair_trig u0 (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .txThr(txThr), .rxThr(rxThr), .wide32(wide32),
    .busWrValid(busWrValid), .busWrData(busWrData), .busRdReq(busRdReq), .busRdData(busRdData),
    .shTxPop(shTxPop), .shTxData(shTxData), .shRxPush(shRxPush), .shRxData(shRxData),
    .txReq(txReq), .rxReq(rxReq), .txLevel(txLevel), .rxLevel(rxLevel),
    .txOvf(txOvf), .txUnf(txUnf), .rxOvf(rxOvf), .rxUnf(rxUnf)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pushTx(input logic [31:0] d);
    busWrData = d; busWrValid = 1'b1; cyc(); busWrValid = 1'b0;
  endtask
  task automatic popTx();
    shTxPop = 1'b1; cyc(); shTxPop = 1'b0;
  endtask
  task automatic pushRx(input logic [31:0] d);
    shRxData = d; shRxPush = 1'b1; cyc(); shRxPush = 1'b0;
  endtask
  task automatic popRx();
    busRdReq = 1'b1; cyc(); busRdReq = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; fifoEn = 1'b1; txThr = 2'd0; rxThr = 2'd0; wide32 = 1'b1;
    busWrValid = 1'b0; busRdReq = 1'b0; shTxPop = 1'b0; shRxPush = 1'b0;
    cyc(); cyc();
    rstN = 1'b1;
    cyc(); cyc();
  endtask

  task automatic test_reset_R1();
    @(negedge clk);
    rstN = 1'b0;
    cyc();
    check(txLevel == 0 && rxLevel == 0, "R1 levels", {txLevel, rxLevel}, 0);
    check(!txReq && !rxReq, "R1 requests", {txReq, rxReq}, 0);
    check(!txOvf && !txUnf && !rxOvf && !rxUnf, "R1 flags", {txOvf, txUnf, rxOvf, rxUnf}, 0);
    applyReset();
  endtask

  task automatic test_order_R2();
    applyReset();
    for (int i = 0; i < 8; i++) pushTx(32'h1111_0000 + i);
    check(txLevel == 8, "R2 tx level full", txLevel, 8);
    for (int i = 0; i < 8; i++) begin
      check(shTxData == 32'h1111_0000 + i, "R2 tx order", shTxData, 32'h1111_0000 + i);
      popTx();
    end
    check(txLevel == 0, "R2 tx drained", txLevel, 0);
    for (int i = 0; i < 3; i++) pushRx(32'h7700_00A0 + i);
    check(rxLevel == 3, "R2 rx level", rxLevel, 3);
    for (int i = 0; i < 3; i++) begin
      check(busRdData == 32'h7700_00A0 + i, "R2 rx order", busRdData, 32'h7700_00A0 + i);
      popRx();
    end
    check(rxLevel == 0, "R2 rx drained", rxLevel, 0);
  endtask

  function automatic bit txExp(input int code, input int lvl);
    case (code)
      1:       return (8 - lvl) >= 4;
      2:       return lvl == 0;
      default: return lvl < 8;
    endcase
  endfunction

  function automatic bit rxExp(input int code, input int lvl);
    case (code)
      1:       return lvl >= 4;
      2:       return lvl == 8;
      default: return lvl >= 1;
    endcase
  endfunction

  // R3 R4 R5: every transmit policy code at every occupancy
  task automatic test_tx_policy();
    applyReset();
    for (int lvl = 0; lvl <= 8; lvl++) begin
      for (int code = 0; code < 4; code++) begin
        txThr = 2'(code);
        cyc();
        check(txReq == txExp(code, lvl),
              (code == 1) ? "R4 tx half" : (code == 2) ? "R5 tx empty" : "R3 tx any",
              {txLevel, 3'b0, txReq}, {4'(lvl), 3'b0, txExp(code, lvl)});
      end
      if (lvl < 8) pushTx(32'h0 + lvl);
    end
  endtask

  // R6 R7 R8: every receive policy code at every occupancy
  task automatic test_rx_policy();
    applyReset();
    for (int lvl = 0; lvl <= 8; lvl++) begin
      for (int code = 0; code < 4; code++) begin
        rxThr = 2'(code);
        cyc();
        check(rxReq == rxExp(code, lvl),
              (code == 1) ? "R7 rx half" : (code == 2) ? "R8 rx full" : "R6 rx any",
              {rxLevel, 3'b0, rxReq}, {4'(lvl), 3'b0, rxExp(code, lvl)});
      end
      if (lvl < 8) pushRx(32'h100 + lvl);
    end
  endtask

  task automatic test_timing_R9();
    applyReset();
    txThr = 2'd2; rxThr = 2'd0;
    cyc();
    check(txReq == 1'b1, "R9 tx empty req", txReq, 1);
    pushTx(32'h55);
    check(txLevel == 1 && txReq == 1'b0, "R9 tx same edge", {txLevel, txReq}, {4'd1, 1'b0});
    pushRx(32'h66);
    check(rxLevel == 1 && rxReq == 1'b1, "R9 rx same edge", {rxLevel, rxReq}, {4'd1, 1'b1});
    popRx();
    check(rxLevel == 0 && rxReq == 1'b0, "R9 rx drop same edge", {rxLevel, rxReq}, {4'd0, 1'b0});
  endtask

  task automatic test_overflow_R10();
    applyReset();
    for (int i = 0; i < 8; i++) pushTx(32'hAB00 + i);
    check(txOvf == 1'b0, "R10 no flag at exact fill", txOvf, 0);
    pushTx(32'hDEAD);
    check(txLevel == 8, "R10 tx level held", txLevel, 8);
    check(txOvf == 1'b1, "R10 tx flag", txOvf, 1);
    check(shTxData == 32'hAB00, "R10 head intact", shTxData, 32'hAB00);
    for (int i = 0; i < 7; i++) popTx();
    check(shTxData == 32'hAB07, "R10 tail intact", shTxData, 32'hAB07);
    popTx();
    check(txOvf == 1'b1, "R10 tx sticky", txOvf, 1);
    for (int i = 0; i < 9; i++) pushRx(32'hC0 + i);
    check(rxLevel == 8 && rxOvf == 1'b1, "R10 rx flag", {rxLevel, rxOvf}, {4'd8, 1'b1});
  endtask

  task automatic test_underflow_R11();
    applyReset();
    popTx();
    check(txLevel == 0 && txUnf == 1'b1 && txOvf == 1'b0, "R11 tx underflow",
          {txLevel, txUnf, txOvf}, {4'd0, 1'b1, 1'b0});
    popRx();
    check(rxLevel == 0 && rxUnf == 1'b1, "R11 rx underflow", {rxLevel, rxUnf}, {4'd0, 1'b1});
    pushTx(32'h9);
    check(txLevel == 1 && txUnf == 1'b1, "R11 sticky after push", {txLevel, txUnf}, {4'd1, 1'b1});
  endtask

  task automatic test_bypass_R12();
    applyReset();
    pushRx(32'h3);
    pushRx(32'h4);
    fifoEn = 1'b0;
    cyc();
    check(rxLevel == 0, "R12 flush on disable", rxLevel, 0);
    pushTx(32'hA1);
    check(txLevel == 1 && txReq == 1'b0, "R12 single entry full", {txLevel, txReq}, {4'd1, 1'b0});
    pushTx(32'hB2);
    check(txLevel == 1 && txOvf == 1'b1, "R12 second write dropped", {txLevel, txOvf}, {4'd1, 1'b1});
    check(shTxData == 32'hA1, "R12 holding data", shTxData, 32'hA1);
    popTx();
    txThr = 2'd1;
    cyc();
    check(txReq == 1'b1, "R12 tx half mark one", txReq, 1);
    pushRx(32'hC3);
    rxThr = 2'd2;
    cyc();
    check(rxReq == 1'b1, "R12 rx full at one", rxReq, 1);
    rxThr = 2'd1;
    cyc();
    check(rxReq == 1'b1, "R12 rx half at one", rxReq, 1);
    fifoEn = 1'b1;
    cyc();
    check(rxLevel == 0, "R12 flush on enable", rxLevel, 0);
    pushRx(32'h1);
    pushRx(32'h2);
    check(rxLevel == 2, "R12 capacity restored", rxLevel, 2);
  endtask

  task automatic test_width_R13();
    applyReset();
    wide32 = 1'b0;
    pushTx(32'hA5A5_1234);
    check(shTxData == 32'h0000_0034, "R13 byte write", shTxData, 32'h34);
    pushRx(32'hDEAD_BEEF);
    check(busRdData == 32'h0000_00EF, "R13 byte read", busRdData, 32'hEF);
    wide32 = 1'b1;
    #1;
    check(busRdData == 32'hDEAD_BEEF, "R13 word read", busRdData, 32'hDEAD_BEEF);
    @(negedge clk);
    popTx();
    pushTx(32'hCAFE_F00D);
    check(shTxData == 32'hCAFE_F00D, "R13 word write", shTxData, 32'hCAFE_F00D);
  endtask

  initial begin
    test_reset_R1();
    test_order_R2();
    test_tx_policy();
    test_rx_policy();
    test_timing_R9();
    test_overflow_R10();
    test_underflow_R11();
    test_bypass_R12();
    test_width_R13();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule